// File: doc/BRIEF.md
# PHY Basic Mode Control Register

This block holds the 16-bit basic mode control word of a 10/100 Ethernet PHY. A management port with an address, a write strobe, write data and combinational read data reaches it. Bits of the word go straight to the rest of the PHY as registered control lines: a soft reset, loopback, speed, duplex, auto-negotiation enable, a restart pulse for the auto-negotiation engine, power down and isolate. Two bits clear themselves. The soft-reset bit reads 1 while an internal sequencer holds the PHY in reset for a fixed number of cycles. The restart bit reads 1 until the auto-negotiation engine reports that it has started again.

While auto-negotiation is enabled, the speed and duplex bits read back the negotiated result from the engine, not the last written values, and the speed and duplex outputs follow that result. The isolate bit forces the MII transmit inputs to zero on their way into the PHY and drops the MII output enable. The management port keeps working the whole time.

Two small state machines do the sequencing. The reset sequencer has the states `RS_IDLE` and `RS_HOLD`. A write with bit 15 set moves it from idle to hold (transition *start*). It returns to idle when its counter reaches `RST_CYCLES-1` (transition *expire*). The restart handler has the states `AR_IDLE`, `AR_PULSE` and `AR_WAIT`:
- *request*: idle to pulse.
- *settle*: pulse to wait, when no acknowledge arrives.
- *ack*: pulse or wait to idle, when `an_started_i` is high.
- *cancel*: pulse or wait to idle, on a soft reset or a write that clears bit 12.

Top module: `phy_bmc_reg`

## Requirements
- R1: After `rst_n` is released, address 0 reads 0x3000 when `an_speed_i`=1 and `an_duplex_i`=0. `loopback_o`, `pwrdn_o`, `isolate_o`, `soft_reset_o` and `an_restart_o` are 0, and `an_en_o` and `mii_oe_o` are 1.
- R2: Bits 7:0 of address 0 always read 0. Writes to those bits have no effect. Any other address reads 0x0000, and writes to it leave the control word unchanged.
- R3: With bit 12 clear, bits 14 (loopback), 13 (speed, 1 = 100 Mb/s), 11 (power down) and 8 (full duplex) read back as written. `loopback_o` and `pwrdn_o` follow in the cycle after the write. `speed100_o` and `full_duplex_o` follow one cycle later.
- R4: With bit 12 set, bit 13 reads `an_speed_i` and bit 8 reads `an_duplex_i`. `speed100_o` and `full_duplex_o` follow those inputs one cycle later.
- R5: A write with bit 15 set holds bit 15 and `soft_reset_o` at 1 for exactly `RST_CYCLES` cycles. During that time the control fields stay at their defaults and management writes are ignored. Afterwards the word reads 0x3000 under the R1 inputs.
- R6: A write to address 0 with bits 12 and 9 both set raises `an_restart_o` for exactly one cycle, in the cycle after the write.
- R7: After such a write, bit 9 reads 1 until `an_started_i` is seen high. A write that keeps bit 12 set but clears bit 9 does not end the pending restart.
- R8: While bit 12 is clear, bit 9 reads 0 and writing bit 9 produces no pulse. A write that clears bit 12 abandons a pending restart, so setting bit 12 again does not bring bit 9 back.
- R9: While bit 10 (isolate) is set, `txd_o`, `tx_en_o` and `tx_er_o` are 0 whatever the transmit inputs are, `mii_oe_o` is 0, and the management port still reads and writes. Clearing bit 10 passes the transmit inputs through again.
- R10: While bit 11 (power down) is set, `pwrdn_o` is 1 and management reads and writes are still serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mgmt_addr | input | ADDR_W | Management register address |
| mgmt_we | input | 1 | Management write strobe |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_rdata | output | 16 | Management read data (combinational) |
| an_started_i | input | 1 | Auto-negotiation engine has restarted |
| an_speed_i | input | 1 | Negotiated speed, 1 = 100 Mb/s |
| an_duplex_i | input | 1 | Negotiated duplex, 1 = full |
| soft_reset_o | output | 1 | Soft reset in progress |
| loopback_o | output | 1 | Loopback enable |
| speed100_o | output | 1 | Effective speed, 1 = 100 Mb/s |
| full_duplex_o | output | 1 | Effective duplex |
| an_en_o | output | 1 | Auto-negotiation enable |
| an_restart_o | output | 1 | One-cycle restart request |
| pwrdn_o | output | 1 | Power-down request |
| isolate_o | output | 1 | Isolate request |
| txd_i | input | MII_W | MII transmit data from the MAC |
| tx_en_i | input | 1 | MII transmit enable from the MAC |
| tx_er_i | input | 1 | MII transmit error from the MAC |
| txd_o | output | MII_W | Gated transmit data into the PHY |
| tx_en_o | output | 1 | Gated transmit enable |
| tx_er_o | output | 1 | Gated transmit error |
| mii_oe_o | output | 1 | Output enable for the MII clocks, receive and status pins |

## Verification
The bound checker covers the properties that hold on every cycle:
- Every restart pulse is single, and it only occurs with auto-negotiation enabled.
- The fields sit at their defaults while a soft reset runs, and the reset never outlasts its cycle count.
- Isolation zeroes the transmit path and drops the output enable.
- Bit 9 never reads 1 at address 0 with auto-negotiation off.

Other behaviours depend on a history of writes and acknowledges, so only the directed scenarios can show them:
- The exact reset length.
- That writes are ignored during a reset.
- That a restart survives a bit-9-clear write but is lost when bit 12 is cleared.
- That negotiated speed and duplex are substituted on reads.

// File: rtl/phyc_pkg.sv
package phyc_pkg;

    localparam int BIT_RST = 15;
    localparam int BIT_LB  = 14;
    localparam int BIT_SPD = 13;
    localparam int BIT_ANE = 12;
    localparam int BIT_PD  = 11;
    localparam int BIT_ISO = 10;
    localparam int BIT_ANR = 9;
    localparam int BIT_DPX = 8;
    localparam int WORD_W  = 16;

    typedef enum logic {
        RS_IDLE,
        RS_HOLD
    } rst_state_e;

    typedef enum logic [1:0] {
        AR_IDLE,
        AR_PULSE,
        AR_WAIT
    } ar_state_e;

    typedef struct packed {
        logic loopback;
        logic speed100;
        logic an_en;
        logic pwrdn;
        logic isolate;
        logic duplex;
    } ctl_fields_t;

    localparam ctl_fields_t CTL_DEFAULT = '{
        loopback: 1'b0,
        speed100: 1'b1,
        an_en:    1'b1,
        pwrdn:    1'b0,
        isolate:  1'b0,
        duplex:   1'b0
    };

endpackage

// File: rtl/phyc_rst_seq.sv
module phyc_rst_seq
    import phyc_pkg::*;
#(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;

    rst_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic           last_cycle;

    assign last_cycle = (cnt_q == CW'(HOLD_CYCLES - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: if (start_i)    state_d = RS_HOLD;
            RS_HOLD: if (last_cycle) state_d = RS_IDLE;
            default:                 state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (state_q == RS_HOLD)   cnt_q <= last_cycle ? '0 : cnt_q + 1'b1;
        else                           cnt_q <= '0;
    end

    always_comb begin
        busy_o = (state_q == RS_HOLD);
    end

endmodule

// File: rtl/phyc_an_restart.sv
module phyc_an_restart
    import phyc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic cancel_i,
    input  logic ack_i,
    output logic pulse_o,
    output logic pend_o
);

    ar_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AR_IDLE: begin
                if (req_i && !cancel_i) state_d = AR_PULSE;
            end
            AR_PULSE: begin
                if (cancel_i || ack_i)  state_d = AR_IDLE;
                else                    state_d = AR_WAIT;
            end
            AR_WAIT: begin
                if (cancel_i || ack_i)  state_d = AR_IDLE;
            end
            default: state_d = AR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= AR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pulse_o = (state_q == AR_PULSE);
        pend_o  = (state_q != AR_IDLE);
    end

endmodule

// File: rtl/phyc_mii_gate.sv
module phyc_mii_gate #(
    parameter int W = 4
) (
    input  logic         iso_i,
    input  logic [W-1:0] txd_i,
    input  logic         tx_en_i,
    input  logic         tx_er_i,
    output logic [W-1:0] txd_o,
    output logic         tx_en_o,
    output logic         tx_er_o,
    output logic         oe_o
);

    always_comb begin
        txd_o   = iso_i ? '0   : txd_i;
        tx_en_o = iso_i ? 1'b0 : tx_en_i;
        tx_er_o = iso_i ? 1'b0 : tx_er_i;
        oe_o    = ~iso_i;
    end

endmodule

// File: rtl/phy_bmc_reg.sv
module phy_bmc_reg
    import phyc_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int REG_ADDR   = 0,
    parameter int RST_CYCLES = 16,
    parameter int MII_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mgmt_addr,
    input  logic              mgmt_we,
    input  logic [15:0]       mgmt_wdata,
    output logic [15:0]       mgmt_rdata,
    input  logic              an_started_i,
    input  logic              an_speed_i,
    input  logic              an_duplex_i,
    output logic              soft_reset_o,
    output logic              loopback_o,
    output logic              speed100_o,
    output logic              full_duplex_o,
    output logic              an_en_o,
    output logic              an_restart_o,
    output logic              pwrdn_o,
    output logic              isolate_o,
    input  logic [MII_W-1:0]  txd_i,
    input  logic              tx_en_i,
    input  logic              tx_er_i,
    output logic [MII_W-1:0]  txd_o,
    output logic              tx_en_o,
    output logic              tx_er_o,
    output logic              mii_oe_o
);

    ctl_fields_t fields_q;
    logic        rst_busy;
    logic        ar_pend;
    logic        addr_hit;
    logic        wr_hit;
    logic        rst_start;
    logic        ar_req;
    logic        ar_cancel;
    logic        eff_speed;
    logic        eff_duplex;
    logic        unused_wbits;

    assign unused_wbits = ^mgmt_wdata[7:0];

    assign addr_hit  = (mgmt_addr == ADDR_W'(REG_ADDR));
    assign wr_hit    = mgmt_we && addr_hit && !rst_busy;
    assign rst_start = wr_hit && mgmt_wdata[BIT_RST];
    assign ar_req    = wr_hit && !mgmt_wdata[BIT_RST]
                       && mgmt_wdata[BIT_ANE] && mgmt_wdata[BIT_ANR];
    assign ar_cancel = rst_start || (wr_hit && !mgmt_wdata[BIT_ANE]);

    phyc_rst_seq #(.HOLD_CYCLES(RST_CYCLES)) rst_seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (rst_start),
        .busy_o  (rst_busy)
    );

    phyc_an_restart an_restart_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (ar_req),
        .cancel_i (ar_cancel),
        .ack_i    (an_started_i),
        .pulse_o  (an_restart_o),
        .pend_o   (ar_pend)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields_q <= CTL_DEFAULT;
        end else if (rst_start || rst_busy) begin
            fields_q <= CTL_DEFAULT;
        end else if (wr_hit) begin
            fields_q.loopback <= mgmt_wdata[BIT_LB];
            fields_q.speed100 <= mgmt_wdata[BIT_SPD];
            fields_q.an_en    <= mgmt_wdata[BIT_ANE];
            fields_q.pwrdn    <= mgmt_wdata[BIT_PD];
            fields_q.isolate  <= mgmt_wdata[BIT_ISO];
            fields_q.duplex   <= mgmt_wdata[BIT_DPX];
        end
    end

    assign eff_speed  = fields_q.an_en ? an_speed_i  : fields_q.speed100;
    assign eff_duplex = fields_q.an_en ? an_duplex_i : fields_q.duplex;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            speed100_o    <= CTL_DEFAULT.speed100;
            full_duplex_o <= CTL_DEFAULT.duplex;
        end else begin
            speed100_o    <= eff_speed;
            full_duplex_o <= eff_duplex;
        end
    end

    always_comb begin
        mgmt_rdata = '0;
        if (addr_hit) begin
            mgmt_rdata[BIT_RST] = rst_busy;
            mgmt_rdata[BIT_LB]  = fields_q.loopback;
            mgmt_rdata[BIT_SPD] = eff_speed;
            mgmt_rdata[BIT_ANE] = fields_q.an_en;
            mgmt_rdata[BIT_PD]  = fields_q.pwrdn;
            mgmt_rdata[BIT_ISO] = fields_q.isolate;
            mgmt_rdata[BIT_ANR] = ar_pend && fields_q.an_en;
            mgmt_rdata[BIT_DPX] = eff_duplex;
        end
    end

    assign soft_reset_o = rst_busy;
    assign loopback_o   = fields_q.loopback;
    assign an_en_o      = fields_q.an_en;
    assign pwrdn_o      = fields_q.pwrdn;
    assign isolate_o    = fields_q.isolate;

    phyc_mii_gate #(.W(MII_W)) mii_gate_i (
        .iso_i   (fields_q.isolate),
        .txd_i   (txd_i),
        .tx_en_i (tx_en_i),
        .tx_er_i (tx_er_i),
        .txd_o   (txd_o),
        .tx_en_o (tx_en_o),
        .tx_er_o (tx_er_o),
        .oe_o    (mii_oe_o)
    );

endmodule

// File: rtl/phy_bmc_reg_chk.sv
module phy_bmc_reg_chk #(
    parameter int ADDR_W     = 5,
    parameter int REG_ADDR   = 0,
    parameter int RST_CYCLES = 16,
    parameter int MII_W      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mgmt_addr,
    input logic [15:0]       mgmt_rdata,
    input logic              soft_reset_o,
    input logic              loopback_o,
    input logic              an_en_o,
    input logic              an_restart_o,
    input logic              pwrdn_o,
    input logic              isolate_o,
    input logic [MII_W-1:0]  txd_o,
    input logic              tx_en_o,
    input logic              tx_er_o,
    input logic              mii_oe_o
);

    int rst_run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            rst_run_cnt <= 0;
        else if (soft_reset_o) rst_run_cnt <= rst_run_cnt + 1;
        else                   rst_run_cnt <= 0;
    end

    assert_reset_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_run_cnt <= RST_CYCLES);

    assert_reset_defaults_R5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_o |-> (!loopback_o && !pwrdn_o && !isolate_o && an_en_o));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart_o |=> !an_restart_o);

    assert_pulse_needs_an_R8: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart_o |-> an_en_o);

    assert_restart_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mgmt_addr == ADDR_W'(REG_ADDR)) && !an_en_o) |-> !mgmt_rdata[9]);

    assert_isolate_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        isolate_o |-> (txd_o == '0 && !tx_en_o && !tx_er_o && !mii_oe_o));

endmodule

bind phy_bmc_reg phy_bmc_reg_chk #(
    .ADDR_W     (ADDR_W),
    .REG_ADDR   (REG_ADDR),
    .RST_CYCLES (RST_CYCLES),
    .MII_W      (MII_W)
) chk_i (.*);

// File: tb/phy_bmc_reg_tb_top.sv
module phy_bmc_reg_tb_top;

    localparam int ADDR_W = 5;
    localparam int NRST   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] mgmt_addr = '0;
    logic              mgmt_we = 1'b0;
    logic [15:0]       mgmt_wdata = '0;
    logic [15:0]       mgmt_rdata;
    logic              an_started_i = 1'b0;
    logic              an_speed_i = 1'b1;
    logic              an_duplex_i = 1'b0;
    logic              soft_reset_o, loopback_o, speed100_o, full_duplex_o;
    logic              an_en_o, an_restart_o, pwrdn_o, isolate_o;
    logic [3:0]        txd_i = '0;
    logic              tx_en_i = 1'b0, tx_er_i = 1'b0;
    logic [3:0]        txd_o;
    logic              tx_en_o, tx_er_o, mii_oe_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    phy_bmc_reg dut_i (
        .clk(clk), .rst_n(rst_n), .mgmt_addr(mgmt_addr), .mgmt_we(mgmt_we),
        .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata),
        .an_started_i(an_started_i), .an_speed_i(an_speed_i), .an_duplex_i(an_duplex_i),
        .soft_reset_o(soft_reset_o), .loopback_o(loopback_o), .speed100_o(speed100_o),
        .full_duplex_o(full_duplex_o), .an_en_o(an_en_o), .an_restart_o(an_restart_o),
        .pwrdn_o(pwrdn_o), .isolate_o(isolate_o), .txd_i(txd_i), .tx_en_i(tx_en_i),
        .tx_er_i(tx_er_i), .txd_o(txd_o), .tx_en_o(tx_en_o), .tx_er_o(tx_er_o),
        .mii_oe_o(mii_oe_o)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [15:0] d);
        mgmt_addr  = a;
        mgmt_wdata = d;
        mgmt_we    = 1'b1;
        @(negedge clk);
        mgmt_we    = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [15:0] d);
        mgmt_addr = a;
        #1;
        d = mgmt_rdata;
    endtask

    task automatic t_reset_defaults();
        logic [15:0] v;
        rd(0, v);
        chk("R1 word", v, 16'h3000);
        chk("R1 outputs", {soft_reset_o, loopback_o, pwrdn_o, isolate_o, an_restart_o, an_en_o, mii_oe_o},
            16'h0003);
    endtask

    task automatic t_unused_bits();
        logic [15:0] v;
        wr(0, 16'h00FF);
        rd(0, v);
        chk("R2 low bits", v, 16'h0000);
        wr(0, 16'h1000);
        wr(1, 16'hFFFF);
        rd(1, v);
        chk("R2 other addr reads", v, 16'h0000);
        rd(0, v);
        chk("R2 other addr write", v, 16'h3000);
    endtask

    task automatic t_manual_mode();
        logic [15:0] v;
        wr(0, 16'h41FF);
        rd(0, v);
        chk("R3 readback", v, 16'h4100);
        chk("R3 loopback_o", {15'd0, loopback_o}, 16'h0001);
        @(negedge clk);
        chk("R3 speed/duplex out", {14'd0, speed100_o, full_duplex_o}, 16'h0001);
        wr(0, 16'h2800);
        rd(0, v);
        chk("R3 R10 pd readback", v, 16'h2800);
        chk("R10 pwrdn_o", {15'd0, pwrdn_o}, 16'h0001);
        @(negedge clk);
        chk("R3 speed100 out", {14'd0, speed100_o, full_duplex_o}, 16'h0002);
    endtask

    task automatic t_an_result();
        logic [15:0] v;
        wr(0, 16'h1000);
        an_speed_i  = 1'b0;
        an_duplex_i = 1'b1;
        rd(0, v);
        chk("R4 negotiated read", v, 16'h1100);
        @(negedge clk);
        chk("R4 negotiated out", {14'd0, speed100_o, full_duplex_o}, 16'h0001);
        an_speed_i  = 1'b1;
        an_duplex_i = 1'b0;
        rd(0, v);
        chk("R4 follows input", v, 16'h3000);
    endtask

    task automatic t_restart();
        logic [15:0] v;
        wr(0, 16'h1200);
        chk("R6 pulse high", {15'd0, an_restart_o}, 16'h0001);
        rd(0, v);
        chk("R7 bit9 pending", v, 16'h3200);
        @(negedge clk);
        chk("R6 pulse single", {15'd0, an_restart_o}, 16'h0000);
        wr(0, 16'h1000);
        rd(0, v);
        chk("R7 clear-write no abort", v, 16'h3200);
        an_started_i = 1'b1;
        @(negedge clk);
        an_started_i = 1'b0;
        rd(0, v);
        chk("R7 ack clears", v, 16'h3000);
    endtask

    task automatic t_restart_no_an();
        logic [15:0] v;
        logic        seen;
        wr(0, 16'h0200);
        seen = an_restart_o;
        rd(0, v);
        chk("R8 no pulse", {15'd0, seen}, 16'h0000);
        chk("R8 bit9 zero", v, 16'h0000);
        wr(0, 16'h1200);
        wr(0, 16'h0000);
        wr(0, 16'h1000);
        rd(0, v);
        chk("R8 cancel sticks", v, 16'h3000);
    endtask

    task automatic t_isolate();
        logic [15:0] v;
        txd_i = 4'hA; tx_en_i = 1'b1; tx_er_i = 1'b1;
        wr(0, 16'h1400);
        #1;
        chk("R9 gated tx", {8'd0, txd_o, tx_en_o, tx_er_o, mii_oe_o, 1'b0}, 16'h0000);
        rd(0, v);
        chk("R9 mgmt live", v, 16'h3400);
        wr(0, 16'h1000);
        #1;
        chk("R9 pass through", {8'd0, txd_o, tx_en_o, tx_er_o, mii_oe_o, 1'b0}, 16'h00AE);
        txd_i = '0; tx_en_i = 1'b0; tx_er_i = 1'b0;
    endtask

    task automatic t_soft_reset();
        logic [15:0] v;
        wr(0, 16'h4C00);
        wr(0, 16'h8000);
        for (int i = 0; i < NRST; i++) begin
            rd(0, v);
            chk("R5 bit15 held", {v[15], soft_reset_o, loopback_o, pwrdn_o, isolate_o, 11'd0},
                16'hC000);
            if (i == 0) begin
                mgmt_wdata = 16'h4000;
                mgmt_we    = 1'b1;
            end
            @(negedge clk);
            mgmt_we = 1'b0;
        end
        rd(0, v);
        chk("R5 done word", v, 16'h3000);
        chk("R5 soft_reset_o low", {15'd0, soft_reset_o}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_defaults();
        t_unused_bits();
        t_manual_mode();
        t_an_result();
        t_restart();
        t_restart_no_an();
        t_isolate();
        t_soft_reset();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule